// File: doc/BRIEF.md
# Cross-Unit Replay Queue Verifier

This block checks the results of a pipeline that sends every instruction to one of three unit classes: arithmetic, memory-address, or special-function. It does not re-execute each instruction straight away. Instead, each executed instruction is held in a small queue together with its opcode, two operands, destination register and original result. The entry waits there until a unit of its class would otherwise sit idle. That happens when the instruction in decode belongs to a different class, or when decode is stalled and issues nothing. The block then sends the oldest suitable entry to that unit. When the unit returns its result, tagged with the entry's slot number, the block compares it with the stored one and raises an error pulse if the two differ.

Results that have not been checked must not be consumed. The block therefore stalls decode while a source register matches the destination of any unverified instruction. It also stalls decode when the queue could overflow. Every stall cycle is used to drain the queue, because a stalled decode leaves all units free.

Top module: `replay_verifier`

## Requirements
- R1: After reset the queue is empty. `dec_stall`, `rp_valid` and `err_valid` are all low.
- R2: Each instruction presented on the execute port (`ex_valid` high) is stored in the lowest-numbered free slot. When that entry is replayed, `rp_tag` gives the slot number, and `rp_opcode`, `rp_opnd_a` and `rp_opnd_b` carry the stored values.
- R3: Class codes are 0 for arithmetic, 1 for memory and 2 for special-function. When decode is valid and not stalled, a replay is launched in the same cycle for a waiting entry whose class differs from `dec_class`. `rp_class` gives that entry's class. With `dec_valid` low, no replay is launched.
- R4: No replay is launched while every waiting entry has the same class as the unstalled decode instruction.
- R5: `dec_stall` is high while either decode source register equals the destination of a stored entry or of the instruction on the execute port in that cycle.
- R6: `dec_stall` is high when decode is valid and the number of stored entries plus `ex_valid` is at least DEPTH.
- R7: While decode is stalled, the oldest waiting entry is replayed regardless of its class.
- R8: Among the eligible entries, the one stored earliest is chosen, whatever its slot number.
- R9: When a returned result differs from the stored result, `err_valid` is high for one cycle in the cycle after the return, with `err_dst` and `err_opcode` taken from the entry. A matching result raises no error.
- R10: A returning entry leaves the queue. Its destination stops causing a hazard stall in the same cycle as the return.
- R11: An entry whose replay is in flight is not selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_class | input | 2 | Unit class of the decode instruction |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| dec_stall | output | 1 | Hold the decode instruction this cycle |
| ex_valid | input | 1 | An executed instruction is presented for storage |
| ex_class | input | 2 | Its unit class |
| ex_opcode | input | OPC_W | Its opcode |
| ex_dst | input | REG_W | Its destination register |
| ex_opnd_a | input | DATA_W | Its first operand value |
| ex_opnd_b | input | DATA_W | Its second operand value |
| ex_result | input | DATA_W | Its original result |
| rp_valid | output | 1 | Replay launched this cycle |
| rp_class | output | 2 | Unit class that must run the replay |
| rp_opcode | output | OPC_W | Replayed opcode |
| rp_opnd_a | output | DATA_W | Replayed first operand |
| rp_opnd_b | output | DATA_W | Replayed second operand |
| rp_tag | output | IDX_W | Slot of the replayed entry |
| rb_valid | input | 1 | A replay result returns |
| rb_tag | input | IDX_W | Slot the returning result belongs to |
| rb_result | input | DATA_W | Recomputed result |
| err_valid | output | 1 | Mismatch detected |
| err_dst | output | REG_W | Destination of the mismatching entry |
| err_opcode | output | OPC_W | Opcode of the mismatching entry |

## Verification
The hardest situation to reach from the ports is a queue in which age order and slot order disagree. In that state the oldest entry sits in a higher slot than a younger one. The bench creates it by storing two entries and retiring the one in slot 0. A new instruction then takes slot 0, and a decode of a third class must pick slot 1. The bench also reaches the fullness boundary by holding decode on a same-class instruction while the fourth entry arrives. That checks both the stall and the forced replay of the oldest entry on its own class.

// File: rtl/rvq_pkg.sv
package rvq_pkg;
   typedef enum logic [1:0] {
      CL_ARITH = 2'd0,
      CL_MEM   = 2'd1,
      CL_SPEC  = 2'd2,
      CL_RSVD  = 2'd3
   } unit_class_e;

   localparam int CLS_W = 2;
endpackage

// File: rtl/rvq_store.sv
module rvq_store
   import rvq_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int OPC_W  = 8,
   parameter int REG_W  = 6,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_en,
   input  unit_class_e          alloc_cls,
   input  logic [OPC_W-1:0]     alloc_op,
   input  logic [REG_W-1:0]     alloc_dst,
   input  logic [DATA_W-1:0]    alloc_a,
   input  logic [DATA_W-1:0]    alloc_b,
   input  logic [DATA_W-1:0]    alloc_res,
   input  logic                 launch_en,
   input  logic [IDX_W-1:0]     launch_idx,
   input  logic                 free_en,
   input  logic [IDX_W-1:0]     free_idx,
   output logic [DEPTH-1:0]     valid_q,
   output logic [DEPTH-1:0]     pend_q,
   output logic [DEPTH-1:0]     older_q [DEPTH],
   output unit_class_e          cls_q   [DEPTH],
   output logic [OPC_W-1:0]     op_q    [DEPTH],
   output logic [REG_W-1:0]     dst_q   [DEPTH],
   output logic [DATA_W-1:0]    a_q     [DEPTH],
   output logic [DATA_W-1:0]    b_q     [DEPTH],
   output logic [DATA_W-1:0]    res_q   [DEPTH]
);
   logic [IDX_W-1:0] slot_free;
   logic             any_free;
   logic             alloc_go;

   // lowest-numbered empty slot
   always_comb begin
      slot_free = '0;
      any_free  = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            slot_free = IDX_W'(i);
            any_free  = 1'b1;
         end
      end
   end

   assign alloc_go = alloc_en && any_free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         pend_q  <= '0;
         for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_go && slot_free == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
               pend_q[i]  <= 1'b0;
            end else if (free_en && free_idx == IDX_W'(i)) begin
               valid_q[i] <= 1'b0;
               pend_q[i]  <= 1'b0;
            end else if (launch_en && launch_idx == IDX_W'(i)) begin
               pend_q[i]  <= 1'b1;
            end
         end
         // age matrix: older_q[j][k] set means slot j was stored before slot k
         if (alloc_go) begin
            for (int j = 0; j < DEPTH; j++) begin
               older_q[slot_free][j] <= 1'b0;
               if (IDX_W'(j) != slot_free) older_q[j][slot_free] <= valid_q[j];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_go) begin
         cls_q[slot_free] <= alloc_cls;
         op_q[slot_free]  <= alloc_op;
         dst_q[slot_free] <= alloc_dst;
         a_q[slot_free]   <= alloc_a;
         b_q[slot_free]   <= alloc_b;
         res_q[slot_free] <= alloc_res;
      end
   end
endmodule

// File: rtl/rvq_pick.sv
module rvq_pick #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2
) (
   input  logic [DEPTH-1:0] elig,
   input  logic [DEPTH-1:0] older [DEPTH],
   output logic             gnt_any,
   output logic [IDX_W-1:0] gnt_idx
);
   logic [DEPTH-1:0] gnt;

   for (genvar i = 0; i < DEPTH; i++) begin : g_col
      logic [DEPTH-1:0] beats;
      for (genvar j = 0; j < DEPTH; j++) begin : g_row
         assign beats[j] = older[j][i];
      end
      assign gnt[i] = elig[i] && !(|(elig & beats));
   end

   assign gnt_any = |gnt;

   always_comb begin
      gnt_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (gnt[i]) gnt_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/rvq_hazard.sv
module rvq_hazard #(
   parameter int DEPTH     = 4,
   parameter int REG_W     = 6,
   parameter bit EX_HAZARD = 1'b1
) (
   input  logic [DEPTH-1:0] live,
   input  logic [REG_W-1:0] dst [DEPTH],
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   input  logic             ex_valid,
   input  logic [REG_W-1:0] ex_dst,
   output logic             hit
);
   logic [DEPTH-1:0] match;
   logic             ex_hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = live[i] && (dst[i] == src_a || dst[i] == src_b);
   end

   if (EX_HAZARD) begin : g_ex_on
      assign ex_hit = ex_valid && (ex_dst == src_a || ex_dst == src_b);
   end else begin : g_ex_off
      assign ex_hit = 1'b0;
   end

   assign hit = (|match) || ex_hit;
endmodule

// File: rtl/replay_verifier.sv
module replay_verifier
   import rvq_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int OPC_W     = 8,
   parameter int REG_W     = 6,
   parameter int DATA_W    = 32,
   parameter bit EX_HAZARD = 1'b1,
   parameter int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_valid,
   input  logic [1:0]         dec_class,
   input  logic [REG_W-1:0]   dec_src_a,
   input  logic [REG_W-1:0]   dec_src_b,
   output logic               dec_stall,
   input  logic               ex_valid,
   input  logic [1:0]         ex_class,
   input  logic [OPC_W-1:0]   ex_opcode,
   input  logic [REG_W-1:0]   ex_dst,
   input  logic [DATA_W-1:0]  ex_opnd_a,
   input  logic [DATA_W-1:0]  ex_opnd_b,
   input  logic [DATA_W-1:0]  ex_result,
   output logic               rp_valid,
   output logic [1:0]         rp_class,
   output logic [OPC_W-1:0]   rp_opcode,
   output logic [DATA_W-1:0]  rp_opnd_a,
   output logic [DATA_W-1:0]  rp_opnd_b,
   output logic [IDX_W-1:0]   rp_tag,
   input  logic               rb_valid,
   input  logic [IDX_W-1:0]   rb_tag,
   input  logic [DATA_W-1:0]  rb_result,
   output logic               err_valid,
   output logic [REG_W-1:0]   err_dst,
   output logic [OPC_W-1:0]   err_opcode
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("replay_verifier: DEPTH must lie in 2..32");
   end
   if (IDX_W != $clog2(DEPTH)) begin : g_bad_idx
      $error("replay_verifier: IDX_W must equal clog2(DEPTH)");
   end
   if (OPC_W < 1 || REG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("replay_verifier: field widths must be positive");
   end

   logic [DEPTH-1:0]  valid_q, pend_q, wait_vec, retire_vec, elig;
   logic [DEPTH-1:0]  older_q [DEPTH];
   unit_class_e       cls_q   [DEPTH];
   logic [OPC_W-1:0]  op_q    [DEPTH];
   logic [REG_W-1:0]  dst_q   [DEPTH];
   logic [DATA_W-1:0] a_q     [DEPTH];
   logic [DATA_W-1:0] b_q     [DEPTH];
   logic [DATA_W-1:0] res_q   [DEPTH];

   logic [CNT_W-1:0]  occ;
   logic [CNT_W:0]    occ_next_hi;
   logic              haz_hit, full_stall, wait_any, pick_any, ret_ok, mismatch;
   logic [IDX_W-1:0]  pick_idx;

   assign occ         = CNT_W'($countones(valid_q));
   assign occ_next_hi = {1'b0, occ} + (CNT_W + 1)'(ex_valid);
   assign wait_vec    = valid_q & ~pend_q;
   assign wait_any    = |wait_vec;

   assign ret_ok   = rb_valid && valid_q[rb_tag] && pend_q[rb_tag];
   assign mismatch = ret_ok && (res_q[rb_tag] != rb_result);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign retire_vec[i] = ret_ok && (rb_tag == IDX_W'(i));
      assign elig[i] = wait_vec[i] && (dec_stall || cls_q[i] != unit_class_e'(dec_class));
   end

   rvq_store #(
      .DEPTH(DEPTH), .OPC_W(OPC_W), .REG_W(REG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (ex_valid),
      .alloc_cls (unit_class_e'(ex_class)),
      .alloc_op  (ex_opcode),
      .alloc_dst (ex_dst),
      .alloc_a   (ex_opnd_a),
      .alloc_b   (ex_opnd_b),
      .alloc_res (ex_result),
      .launch_en (rp_valid),
      .launch_idx(pick_idx),
      .free_en   (ret_ok),
      .free_idx  (rb_tag),
      .valid_q   (valid_q),
      .pend_q    (pend_q),
      .older_q   (older_q),
      .cls_q     (cls_q),
      .op_q      (op_q),
      .dst_q     (dst_q),
      .a_q       (a_q),
      .b_q       (b_q),
      .res_q     (res_q)
   );

   rvq_hazard #(
      .DEPTH(DEPTH), .REG_W(REG_W), .EX_HAZARD(EX_HAZARD)
   ) u_hazard (
      .live    (valid_q & ~retire_vec),
      .dst     (dst_q),
      .src_a   (dec_src_a),
      .src_b   (dec_src_b),
      .ex_valid(ex_valid),
      .ex_dst  (ex_dst),
      .hit     (haz_hit)
   );

   rvq_pick #(
      .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_pick (
      .elig   (elig),
      .older  (older_q),
      .gnt_any(pick_any),
      .gnt_idx(pick_idx)
   );

   assign full_stall = dec_valid && (occ_next_hi >= (CNT_W + 1)'(DEPTH));
   assign dec_stall  = (dec_valid && haz_hit) || full_stall;

   assign rp_valid  = dec_valid && pick_any;
   assign rp_tag    = pick_idx;
   assign rp_class  = cls_q[pick_idx];
   assign rp_opcode = op_q[pick_idx];
   assign rp_opnd_a = a_q[pick_idx];
   assign rp_opnd_b = b_q[pick_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_valid  <= 1'b0;
         err_dst    <= '0;
         err_opcode <= '0;
      end else begin
         err_valid <= mismatch;
         if (mismatch) begin
            err_dst    <= dst_q[rb_tag];
            err_opcode <= op_q[rb_tag];
         end
      end
   end
endmodule

// File: rtl/replay_verifier_chk.sv
module replay_verifier_chk #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_valid,
   input logic [1:0]       dec_class,
   input logic             dec_stall,
   input logic             ex_valid,
   input logic             rp_valid,
   input logic [1:0]       rp_class,
   input logic             rb_valid,
   input logic             err_valid,
   input logic [CNT_W-1:0] occ,
   input logic             wait_any
);
   p_cross_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_valid && !dec_stall) |-> (rp_class != dec_class));

   p_no_dec_no_replay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !rp_valid);

   p_stall_needs_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stall |-> dec_valid);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid |-> (occ < CNT_W'(DEPTH)));

   p_full_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && occ == CNT_W'(DEPTH)) |-> dec_stall);

   p_stall_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_stall && wait_any) |-> rp_valid);

   p_err_after_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> $past(rb_valid));
endmodule

bind replay_verifier replay_verifier_chk #(
   .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dec_valid(dec_valid),
   .dec_class(dec_class),
   .dec_stall(dec_stall),
   .ex_valid (ex_valid),
   .rp_valid (rp_valid),
   .rp_class (rp_class),
   .rb_valid (rb_valid),
   .err_valid(err_valid),
   .occ      (occ),
   .wait_any (wait_any)
);

// File: tb/replay_verifier_tb.sv
`timescale 1ns/1ps
module replay_verifier_tb;
   localparam int DEPTH = 4;
   localparam int IDX_W = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_valid;
   logic [1:0]  dec_class;
   logic [5:0]  dec_src_a, dec_src_b;
   logic        dec_stall;
   logic        ex_valid;
   logic [1:0]  ex_class;
   logic [7:0]  ex_opcode;
   logic [5:0]  ex_dst;
   logic [31:0] ex_opnd_a, ex_opnd_b, ex_result;
   logic        rp_valid;
   logic [1:0]  rp_class;
   logic [7:0]  rp_opcode;
   logic [31:0] rp_opnd_a, rp_opnd_b;
   logic [IDX_W-1:0] rp_tag;
   logic        rb_valid;
   logic [IDX_W-1:0] rb_tag;
   logic [31:0] rb_result;
   logic        err_valid;
   logic [5:0]  err_dst;
   logic [7:0]  err_opcode;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   replay_verifier #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(dec_valid), .dec_class(dec_class),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_stall(dec_stall),
      .ex_valid(ex_valid), .ex_class(ex_class), .ex_opcode(ex_opcode),
      .ex_dst(ex_dst), .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
      .ex_result(ex_result),
      .rp_valid(rp_valid), .rp_class(rp_class), .rp_opcode(rp_opcode),
      .rp_opnd_a(rp_opnd_a), .rp_opnd_b(rp_opnd_b), .rp_tag(rp_tag),
      .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_result(rb_result),
      .err_valid(err_valid), .err_dst(err_dst), .err_opcode(err_opcode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      dec_valid = 0; dec_class = 0; dec_src_a = 6'd60; dec_src_b = 6'd61;
      ex_valid = 0; ex_class = 0; ex_opcode = 0; ex_dst = 0;
      ex_opnd_a = 0; ex_opnd_b = 0; ex_result = 0;
      rb_valid = 0; rb_tag = 0; rb_result = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic put_ex(input logic [1:0] c, input logic [7:0] op, input logic [5:0] d,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
      ex_valid = 1; ex_class = c; ex_opcode = op; ex_dst = d;
      ex_opnd_a = a; ex_opnd_b = b; ex_result = r;
   endtask

   task automatic put_dec(input logic [1:0] c, input logic [5:0] sa, input logic [5:0] sb);
      dec_valid = 1; dec_class = c; dec_src_a = sa; dec_src_b = sb;
   endtask

   task automatic put_rb(input logic [IDX_W-1:0] t, input logic [31:0] r);
      rb_valid = 1; rb_tag = t; rb_result = r;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic t_reset();
      step(); #1;
      chk("R1 stall", dec_stall, 0);
      chk("R1 rp_valid", rp_valid, 0);
      chk("R1 err_valid", err_valid, 0);
   endtask

   task automatic t_cross();
      step(); put_ex(2'd0, 8'h11, 6'd5, 32'd3, 32'd4, 32'd7);
      step(); put_dec(2'd1, 6'd60, 6'd61); #1;
      chk("R3 replay launched", rp_valid, 1);
      chk("R3 replay class", rp_class, 0);
      chk("R2 tag lowest slot", rp_tag, 0);
      chk("R2 opcode", rp_opcode, 8'h11);
      chk("R2 operand a", rp_opnd_a, 3);
      chk("R2 operand b", rp_opnd_b, 4);
      chk("R3 no stall", dec_stall, 0);
      step(); put_rb(0, 32'd7);
      step(); put_dec(2'd0, 6'd5, 6'd5); #1;
      chk("R9 match no error", err_valid, 0);
      chk("R10 retired dst no hazard", dec_stall, 0);
      chk("R4 empty queue no replay", rp_valid, 0);
   endtask

   task automatic t_same_and_error();
      step(); put_ex(2'd0, 8'h22, 6'd6, 32'd10, 32'd20, 32'd30);
      step(); put_dec(2'd0, 6'd60, 6'd61); #1;
      chk("R4 same class no replay", rp_valid, 0);
      step(); put_dec(2'd2, 6'd60, 6'd61); #1;
      chk("R3 replay on spec decode", rp_valid, 1);
      chk("R3 class arith", rp_class, 0);
      step(); put_rb(0, 32'd31);
      step(); #1;
      chk("R9 mismatch flagged", err_valid, 1);
      chk("R9 err dst", err_dst, 6);
      chk("R9 err opcode", err_opcode, 8'h22);
      step(); #1;
      chk("R9 single pulse", err_valid, 0);
   endtask

   task automatic t_hazard();
      step(); put_ex(2'd0, 8'h33, 6'd9, 32'd0, 32'd1, 32'd1); put_dec(2'd1, 6'd60, 6'd9); #1;
      chk("R5 in-flight dst stall", dec_stall, 1);
      chk("R7 nothing stored no replay", rp_valid, 0);
      step(); put_dec(2'd0, 6'd9, 6'd60); #1;
      chk("R5 stored dst stall", dec_stall, 1);
      chk("R7 forced replay same class", rp_valid, 1);
      chk("R7 forced tag", rp_tag, 0);
      step(); put_dec(2'd0, 6'd9, 6'd60); #1;
      chk("R5 still stalled", dec_stall, 1);
      chk("R11 pending not reselected", rp_valid, 0);
      step(); put_dec(2'd0, 6'd9, 6'd60); put_rb(0, 32'd1); #1;
      chk("R10 stall drops on return", dec_stall, 0);
      step(); #1;
      chk("R9 match no error", err_valid, 0);
   endtask

   task automatic t_oldest();
      step(); put_ex(2'd0, 8'h41, 6'd20, 32'd1, 32'd2, 32'd100);
      step(); put_ex(2'd2, 8'h42, 6'd21, 32'd3, 32'd4, 32'd200);
      step(); put_dec(2'd1, 6'd60, 6'd61); #1;
      chk("R8 oldest first tag", rp_tag, 0);
      step(); put_rb(0, 32'd100);
      step(); put_ex(2'd0, 8'h43, 6'd22, 32'd5, 32'd6, 32'd300);
      step(); put_dec(2'd1, 6'd60, 6'd61); #1;
      chk("R8 older entry in higher slot", rp_tag, 1);
      chk("R8 class of older entry", rp_class, 2);
      chk("R8 opcode of older entry", rp_opcode, 8'h42);
      step(); put_dec(2'd2, 6'd60, 6'd61); #1;
      chk("R11 next pick skips in-flight", rp_tag, 0);
      chk("R2 reused slot opcode", rp_opcode, 8'h43);
      step(); put_rb(1, 32'd200);
      step(); put_rb(0, 32'd300); #1;
      chk("R9 match no error", err_valid, 0);
      step(); #1;
      chk("R9 match no error", err_valid, 0);
   endtask

   task automatic t_full();
      step(); put_ex(2'd0, 8'h50, 6'd30, 32'd0, 32'd0, 32'd500);
      step(); put_ex(2'd0, 8'h51, 6'd31, 32'd0, 32'd0, 32'd501);
      step(); put_ex(2'd0, 8'h52, 6'd32, 32'd0, 32'd0, 32'd502);
      step(); put_dec(2'd0, 6'd60, 6'd61); #1;
      chk("R6 below limit no stall", dec_stall, 0);
      chk("R4 same class no replay", rp_valid, 0);
      step(); put_ex(2'd0, 8'h53, 6'd33, 32'd0, 32'd0, 32'd503); put_dec(2'd0, 6'd60, 6'd61); #1;
      chk("R6 limit stall", dec_stall, 1);
      chk("R7 forced replay", rp_valid, 1);
      chk("R7 forced oldest tag", rp_tag, 0);
      chk("R7 own class", rp_class, 0);
      step(); put_dec(2'd0, 6'd60, 6'd61); #1;
      chk("R6 full stall", dec_stall, 1);
      chk("R11 next oldest", rp_tag, 1);
      step(); put_rb(0, 32'd500);
      step(); put_rb(1, 32'd501);
      step(); put_dec(2'd1, 6'd60, 6'd61); #1;
      chk("R6 room again", dec_stall, 0);
      chk("R3 drain tag", rp_tag, 2);
      step(); put_dec(2'd1, 6'd60, 6'd61); #1;
      chk("R3 drain last tag", rp_tag, 3);
      step(); put_rb(2, 32'd502);
      step(); put_rb(3, 32'd503);
      step(); #1;
      chk("R9 match no error", err_valid, 0);
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_cross();
      t_same_and_error();
      t_hazard();
      t_oldest();
      t_full();
      step();
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end
endmodule